// File: doc/BRIEF.md
# Interrupt Cause Register with Auto-Mask

This block collects hardware event pulses from a network controller into a 32-bit cause register. It drives one interrupt request line. The line is high while any latched cause is also enabled in an interrupt-enable mask. Every incoming event also produces a same-cycle pulse, which the surrounding logic uses to restart its delayed-interrupt timers. Software clears cause bits by writing ones to them. Bit 31 is a pending flag that only hardware controls.

Software changes the enable mask through two addresses. One address ORs the write data into the mask and the other clears the bits that are written as one. An auto-mask register holds an enable flag and a set of enable bits that a read of the cause register may remove. A read of the cause register has one of three outcomes. If the mask is empty, the read clears the causes. If an interrupt is pending and auto-mask is on, the read clears the causes and the auto-mask bits are removed from the mask. In every other case the read has no side effect.

Top module: `irq_cause_reg`

## Requirements
- R1: After reset, the cause, mask and auto-mask registers, the pending flag, `rdata` and `irq` are all zero.
- R2: A pulse on `evt` sets its cause bit on the next clock edge, and `timer_clr` is high in the same cycle as the pulse. The `evt` indices map to cause bits as follows: 0 (ACK frame) to bit 17, 1 (manageability) to bit 18, 2 and 3 (receive queues 0 and 1) to bits 20 and 21, and 4 and 5 (transmit queues 0 and 1) to bits 22 and 23.
- R3: Bit 24 (other) is set by events 0 and 1 and by events 6 (link change), 7 (receiver overrun), 8 (MDIO done) and 9 (small packet). The queue events 2 to 5 leave bit 24 unchanged.
- R4: Bits 19, 30:25 and 16:0 of the cause read-back are always zero. The mask holds only bits 24:20 and 18:17.
- R5: Writing to the cause address (0) clears each cause bit written as 1 and leaves each bit written as 0 unchanged. Writes to bit 31 have no effect.
- R6: A write to the mask-set address (1) ORs the data into the mask. A write to the mask-clear address (2) removes the bits written as 1. A read of either address returns the mask.
- R7: `irq` is high exactly when some cause bit is set and its mask bit is also set.
- R8: The pending flag (bit 31) becomes 1 when an enabled cause is latched. It stays 1 while any cause bit remains set, even after the cause is masked, and it drops to 0 once every cause bit is clear.
- R9: A read of the cause address while the mask is all zero clears every cause bit.
- R10: A read of the cause address while the pending flag is 1 and the auto-mask enable (bit 0 of address 3) is 1 clears every cause bit. The same read removes the auto-mask register's enable bits from the mask.
- R11: A read of the cause address while the mask is non-zero and either the pending flag is 0 or auto-mask is off leaves the cause and mask registers unchanged.
- R12: An event arriving in the same cycle as a clearing read or write keeps its cause bit set. A read returns, one cycle later, the value the register held before any clear.
- R13: The auto-mask register at address 3 stores bit 0 and bits 24:20 and 18:17, and it reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt | input | 10 | One-cycle event pulses, index map in R2/R3 |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Interrupt request |
| timer_clr | output | 1 | Pulse that restarts the delayed-interrupt timers |

## Verification
The hardest case to reach is the auto-mask read. It needs the pending flag set, auto-mask enabled and a non-empty mask all at the same moment. The test reaches it by enabling two causes, arming auto-mask for one of them, and firing that event. It then reads the cause register twice and reads the mask. A related case is a pending flag held while its cause is masked. The test reaches that state by masking the cause after the flag has risen, then checks that reads leave the causes in place. A race between an event and a clear is reached by driving the event pulse and the clearing strobe in the same cycle.

// File: rtl/irq_cause_reg.sv
module irq_cause_reg #(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(0),
  parameter logic [ADDR_W-1:0] A_MSET  = ADDR_W'(1),
  parameter logic [ADDR_W-1:0] A_MCLR  = ADDR_W'(2),
  parameter logic [ADDR_W-1:0] A_AUTO  = ADDR_W'(3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [9:0]        evt,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq,
  output logic              timer_clr
);
  localparam logic [31:0] SRC_M  = 32'h01F6_0000;
  localparam logic [31:0] AUTO_M = SRC_M | 32'h1;

  logic [31:0] cause_q, mask_q, auto_q, rdata_q;
  logic        pend_q;
  logic [31:0] cause_n, mask_n, ev_set, w1c, mset, mclr, am_clr, rd_val;
  logic        pend_n, other, cause_rd, rd_clr;

  assign other  = |{evt[9:6], evt[1:0]};
  assign ev_set = {7'b0, other, evt[5:2], 1'b0, evt[1:0], 17'b0};

  assign cause_rd = rd_en && (addr == A_CAUSE);
  assign rd_clr   = cause_rd && ((mask_q == '0) || (pend_q && auto_q[0]));
  assign am_clr   = (cause_rd && pend_q && auto_q[0]) ? (auto_q & SRC_M) : '0;

  assign w1c  = (wr_en && addr == A_CAUSE) ? (wdata & SRC_M) : '0;
  assign mset = (wr_en && addr == A_MSET)  ? (wdata & SRC_M) : '0;
  assign mclr = (wr_en && addr == A_MCLR)  ? (wdata & SRC_M) : '0;

  assign cause_n = (cause_q & ~w1c & ~{32{rd_clr}}) | ev_set;
  assign mask_n  = (mask_q | mset) & ~mclr & ~am_clr;
  assign pend_n  = (|(cause_n & mask_n)) | (pend_q & (|cause_n));

  always_comb begin
    case (addr)
      A_CAUSE:        rd_val = cause_q | {pend_q, 31'b0};
      A_MSET, A_MCLR: rd_val = mask_q;
      A_AUTO:         rd_val = auto_q;
      default:        rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      mask_q  <= '0;
      auto_q  <= '0;
      pend_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      cause_q <= cause_n;
      mask_q  <= mask_n;
      pend_q  <= pend_n;
      if (wr_en && addr == A_AUTO) auto_q <= wdata & AUTO_M;
      if (rd_en) rdata_q <= rd_val;
    end
  end

  assign rdata     = rdata_q;
  assign irq       = |(cause_q & mask_q);
  assign timer_clr = |evt;
endmodule

// File: rtl/irq_cause_reg_chk.sv
module irq_cause_reg_chk #(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(0)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [9:0]        evt,
  input logic              rd_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       rdata,
  input logic              irq,
  input logic              timer_clr,
  input logic [31:0]       cause_q,
  input logic [31:0]       mask_q,
  input logic              pend_q
);
  p_timer_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |-> timer_clr);
  p_rxq0_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt[2] |=> cause_q[20]);
  p_other_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|{evt[9:6], evt[1:0]}) |=> cause_q[24]);
  p_reserved_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & 32'h7E08_0000) == 32'h0);
  p_pend_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !rd_en && !wr_en) |=> pend_q);
  p_pend_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !rd_en && !wr_en) |=> pend_q);
  p_pend_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_q == 32'h0) |-> !pend_q);
  p_rdclr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_CAUSE && mask_q == 32'h0 && evt == 10'h0) |=> (cause_q == 32'h0));
  p_noside_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr == A_CAUSE && mask_q != 32'h0 && !pend_q && evt == 10'h0)
      |=> ($stable(cause_q) && $stable(mask_q)));
endmodule

bind irq_cause_reg irq_cause_reg_chk #(.ADDR_W(ADDR_W), .A_CAUSE(A_CAUSE)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt(evt), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
  .rdata(rdata), .irq(irq), .timer_clr(timer_clr),
  .cause_q(cause_q), .mask_q(mask_q), .pend_q(pend_q)
);

// File: tb/test_irq_cause_reg.sv
module test_irq_cause_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  evt = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, timer_clr;
  int          n_run = 0, n_fail = 0;
  logic        done = 1'b0;

  always #2 clk = ~clk;

  irq_cause_reg i_irq_cause_reg (
    .clk(clk), .rst_n(rst_n), .evt(evt), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .timer_clr(timer_clr));

  localparam int NV = 11;
  localparam logic [41:0] VEC [NV] = '{
    {10'h001, 32'h0102_0000}, {10'h002, 32'h0104_0000}, {10'h004, 32'h0010_0000},
    {10'h008, 32'h0020_0000}, {10'h010, 32'h0040_0000}, {10'h020, 32'h0080_0000},
    {10'h040, 32'h0100_0000}, {10'h080, 32'h0100_0000}, {10'h100, 32'h0100_0000},
    {10'h200, 32'h0100_0000}, {10'h3FF, 32'h01F6_0000}};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic w, input logic [3:0] a,
                      input logic [31:0] d, input logic [9:0] e);
    rd_en = r; wr_en = w; addr = a; wdata = d; evt = e;
    @(negedge clk);
    rd_en = 0; wr_en = 0; wdata = '0; evt = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    step(1, 0, a, '0, '0);
    d = rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    step(0, 1, a, d, '0);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      summary();
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    chk("R1 rdata at reset", rdata, 32'h0);
    chk("R1 irq at reset", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      rd(4'(a), d);
      chk("R1 register reset value", d, 32'h0);
    end

    wr(4'd1, 32'hFFFF_FFFF);
    rd(4'd1, d); chk("R6 R4 mask set read", d, 32'h01F6_0000);
    wr(4'd2, 32'h0010_0000);
    rd(4'd2, d); chk("R6 mask clear read", d, 32'h01E6_0000);
    wr(4'd1, 32'h0010_0000);
    rd(4'd1, d); chk("R6 mask set again", d, 32'h01F6_0000);

    for (int i = 0; i < NV; i++) begin
      evt = VEC[i][41:32];
      #1;
      chk("R2 timer_clr with event", {31'b0, timer_clr}, 32'h1);
      @(negedge clk);
      evt = '0;
      chk("R7 irq on enabled cause", {31'b0, irq}, 32'h1);
      rd(4'd0, d);
      chk("R2 R3 R8 cause read-back", d, VEC[i][31:0] | 32'h8000_0000);
      wr(4'd0, 32'hFFFF_FFFF);
      rd(4'd0, d);
      chk("R5 R8 cleared by write ones", d, 32'h0);
    end
    chk("R2 timer_clr idle", {31'b0, timer_clr}, 32'h0);

    step(0, 0, 4'd0, '0, 10'h014);
    wr(4'd0, 32'h8000_0000);
    rd(4'd0, d); chk("R5 bit 31 ignores write", d, 32'h8050_0000);
    wr(4'd0, 32'h0000_0000);
    rd(4'd0, d); chk("R5 zero write no effect", d, 32'h8050_0000);
    wr(4'd0, 32'h0010_0000);
    rd(4'd0, d); chk("R5 single bit cleared", d, 32'h8040_0000);
    wr(4'd0, 32'hFFFF_FFFF);

    wr(4'd2, 32'hFFFF_FFFF);
    wr(4'd1, 32'h0050_0000);
    step(0, 0, 4'd0, '0, 10'h004);
    wr(4'd2, 32'h0010_0000);
    chk("R7 irq low once masked", {31'b0, irq}, 32'h0);
    rd(4'd0, d); chk("R8 pending held while masked", d, 32'h8010_0000);
    rd(4'd0, d); chk("R11 auto off read keeps cause", d, 32'h8010_0000);
    wr(4'd0, 32'h0010_0000);
    rd(4'd0, d); chk("R8 pending drops with causes", d, 32'h0);

    step(0, 0, 4'd0, '0, 10'h004);
    rd(4'd0, d); chk("R11 not pending read value", d, 32'h0010_0000);
    rd(4'd0, d); chk("R11 not pending no side effect", d, 32'h0010_0000);
    rd(4'd1, d); chk("R11 mask unchanged", d, 32'h0040_0000);
    wr(4'd0, 32'h0010_0000);

    wr(4'd2, 32'hFFFF_FFFF);
    step(0, 0, 4'd0, '0, 10'h008);
    chk("R7 irq low with empty mask", {31'b0, irq}, 32'h0);
    rd(4'd0, d); chk("R9 read returns cause", d, 32'h0020_0000);
    rd(4'd0, d); chk("R9 empty mask read cleared", d, 32'h0);

    wr(4'd3, 32'hFFFF_FFFF);
    rd(4'd3, d); chk("R13 auto-mask read-back", d, 32'h01F6_0001);
    wr(4'd3, 32'h0040_0001);
    rd(4'd3, d); chk("R13 auto-mask value", d, 32'h0040_0001);
    wr(4'd1, 32'h0050_0000);
    step(0, 0, 4'd0, '0, 10'h010);
    rd(4'd0, d); chk("R10 auto read value", d, 32'h8040_0000);
    rd(4'd0, d); chk("R10 causes cleared", d, 32'h0);
    rd(4'd1, d); chk("R10 auto bits removed from mask", d, 32'h0010_0000);
    chk("R10 irq low after auto read", {31'b0, irq}, 32'h0);
    wr(4'd3, 32'h0);

    step(0, 0, 4'd0, '0, 10'h004);
    step(0, 1, 4'd0, 32'h0010_0000, 10'h004);
    rd(4'd0, d); chk("R12 event beats write clear", d, 32'h8010_0000);
    wr(4'd2, 32'hFFFF_FFFF);
    wr(4'd0, 32'hFFFF_FFFF);
    step(0, 0, 4'd0, '0, 10'h020);
    step(1, 0, 4'd0, '0, 10'h020);
    chk("R12 read shows pre-clear value", rdata, 32'h0080_0000);
    rd(4'd0, d); chk("R12 event beats read clear", d, 32'h0080_0000);
    rd(4'd0, d); chk("R9 cleared after race", d, 32'h0);

    done = 1'b1;
    summary();
  end
endmodule